// File: doc/BRIEF.md
# SD Command Line Token Receiver and Response Serializer

This block sits on the command line of an SD card interface. On the receive side it watches a sampled, one-bit-per-clock command input. It finds the start of a host command token, shifts the whole token in and checks it for integrity. It then hands the command index and argument to the card logic as a one-cycle event. A token that fails any check is reported as an error instead, and the outputs keep the last good command.

On the transmit side, a single start pulse makes the block serialize a response onto the command line, with an output enable around the frame. The start pulse carries a length choice, an index and a payload. The block generates the CRC7 itself. What commands mean, card state and the data lines are handled elsewhere.

Top module: `sdcmd_link`

## Requirements
- R1: After reset, and while the command input stays high, cmd_valid and cmd_err stay low, cmd_idx and cmd_arg read zero, cmd_oe is low, cmd_out is high and rsp_busy is low.
- R2: A token starts with the first 0 sampled on cmd_in while idle and is 48 bits long, MSB first. Counting the start bit as bit 0, bit 1 is the direction bit, bits 2 to 7 are the index, bits 8 to 39 are the argument, bits 40 to 46 are the CRC and bit 47 is the end bit. Zeros inside a token never restart framing.
- R3: The CRC is CRC7 with generator x^7+x^3+1 and an all-zero start value, taken over bits 0 to 39 in line order.
- R4: For a token with the direction bit at 1, a matching CRC and an end bit of 1, cmd_valid is high for exactly the one cycle after the clock edge that samples the end bit. cmd_idx and cmd_arg then show the received index and argument and hold until the next valid token.
- R5: A CRC mismatch raises cmd_err for one cycle at the same point in time that cmd_valid would have risen. cmd_valid stays low and cmd_idx/cmd_arg keep their old values.
- R6: An end bit of 0 is reported as in R5.
- R7: A direction bit of 0 (card to host) is reported as in R5.
- R8: A new start bit may follow an end bit in the very next cycle, and both tokens are reported.
- R9: A rsp_start pulse with rsp_long low, seen while idle, sends 48 bits from the next cycle onward: 0, 0, rsp_idx, rsp_data[31:0], the CRC7 of those first 40 bits, and a 1.
- R10: With rsp_long high the frame is 136 bits: 0, 0, six 1s, rsp_data[119:0], the CRC7 of rsp_data alone (header bits excluded), and a 1.
- R11: cmd_oe and rsp_busy are high exactly for the cycles that carry frame bits. cmd_out is high whenever cmd_oe is low.
- R12: A rsp_start pulse while a response is in progress is ignored: the running frame is unchanged and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one command-line bit per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_in | input | 1 | Sampled command line from the host |
| cmd_valid | output | 1 | One-cycle pulse for a good token |
| cmd_err | output | 1 | One-cycle pulse for a rejected token |
| cmd_idx | output | 6 | Index of the last good token |
| cmd_arg | output | 32 | Argument of the last good token |
| rsp_start | input | 1 | Request to send a response |
| rsp_long | input | 1 | 1 selects the 136-bit response, 0 the 48-bit one |
| rsp_idx | input | 6 | Index field for the short response |
| rsp_data | input | 120 | Payload; the short response uses bits 31:0 |
| rsp_busy | output | 1 | A response is being sent |
| cmd_out | output | 1 | Command line value driven by the card |
| cmd_oe | output | 1 | Output enable for cmd_out |

## Verification
A bit counter or shift window that is off by one does not fail quietly. It moves the cmd_valid pulse away from the single cycle after the end bit, and it mislabels good tokens as errors within one token time, so each expected event is compared against its due cycle. A CRC register that is not cleared between back-to-back tokens shows as a false cmd_err on the second token. On the transmit side, a stale length flag or CRC selector corrupts the frame bits or its length, and this is caught when cmd_oe falls. A start pulse that is accepted while busy shows either as a changed frame or as a second frame.

// File: rtl/sdcmd_pkg.sv
// Shared constants and the one-bit CRC7 step used on the command line.
// Assumes CRC7 with generator x^7+x^3+1, processed MSB first.
package sdcmd_pkg;
    localparam int CRC_W = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

    // Advance the CRC state by one line bit.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
// Serial CRC7 accumulator.
// When en is high it takes one bit. When init is also high it restarts from zero
// in the same cycle, so a new frame can begin right after the previous one.
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             init,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    // Accumulate one bit per enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            crc <= '0;
        else if (en)
            crc <= crc_step(init ? '0 : crc, din);
    end
endmodule

// File: rtl/sdcmd_rx.sv
// Command token receiver.
// Frames a fixed-length token from its start bit and checks the direction bit,
// the CRC and the end bit. It reports a one-cycle good or bad event.
// Assumes cmd_in carries one already-sampled line bit per clock.
module sdcmd_rx
    import sdcmd_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_in,
    output logic             cmd_valid,
    output logic             cmd_err,
    output logic [IDX_W-1:0] cmd_idx,
    output logic [ARG_W-1:0] cmd_arg
);
    localparam int TOK_BITS = 2 + IDX_W + ARG_W + CRC_W + 1;
    localparam int CNT_W    = $clog2(TOK_BITS);
    localparam int SH_W     = TOK_BITS - 2;          // holds line bits 1..TOK_BITS-2
    localparam int DIR_POS  = SH_W - 1;
    localparam int IDX_HI   = SH_W - 2;
    localparam int IDX_LO   = IDX_HI - IDX_W + 1;
    localparam int ARG_HI   = IDX_LO - 1;
    localparam int ARG_LO   = ARG_HI - ARG_W + 1;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(TOK_BITS - 1);
    localparam logic [CNT_W-1:0] CRC_END = CNT_W'(TOK_BITS - CRC_W - 1);

    logic             busy;
    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  sh;
    logic [CRC_W-1:0] crc;
    logic             start;
    logic             last;
    logic             good;

    assign start = !busy && !cmd_in;
    assign last  = busy && (cnt == LAST);
    assign good  = sh[DIR_POS] && cmd_in && (sh[CRC_W-1:0] == crc);

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (start || (busy && (cnt < CRC_END))),
        .init  (!busy),
        .din   (cmd_in),
        .crc   (crc)
    );

    // Track the position of the incoming bit inside the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CNT_W'(1);
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Shift the token bits in, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (start || busy)
            sh <= {sh[SH_W-2:0], cmd_in};
    end

    // Judge the token on its end bit and publish the fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_idx   <= '0;
            cmd_arg   <= '0;
        end else begin
            cmd_valid <= last && good;
            cmd_err   <= last && !good;
            if (last && good) begin
                cmd_idx <= sh[IDX_HI:IDX_LO];
                cmd_arg <= sh[ARG_HI:ARG_LO];
            end
        end
    end
endmodule

// File: rtl/sdcmd_tx.sv
// Response serializer.
// Sends a short frame (header, index, argument) or a long frame (header, all-ones
// index field, body), followed by a generated CRC7 and an end bit.
// For the long frame the CRC covers the body only.
// Assumes BODY_W > ARG_W. Start requests while busy are dropped.
module sdcmd_tx
    import sdcmd_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int ARG_W  = 32,
    parameter int BODY_W = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              long_sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BODY_W-1:0] data,
    output logic              busy,
    output logic              line
);
    localparam int HDR_W      = 2 + IDX_W;
    localparam int SHORT_DATA = HDR_W + ARG_W;
    localparam int LONG_DATA  = HDR_W + BODY_W;
    localparam int LONG_BITS  = LONG_DATA + CRC_W + 1;
    localparam int SHORT_BITS = SHORT_DATA + CRC_W + 1;
    localparam int CNT_W      = $clog2(LONG_BITS);
    localparam int CSEL_W     = $clog2(CRC_W);
    localparam logic [CNT_W-1:0] S_DATA = CNT_W'(SHORT_DATA);
    localparam logic [CNT_W-1:0] L_DATA = CNT_W'(LONG_DATA);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SHORT_BITS - 1);
    localparam logic [CNT_W-1:0] L_LAST = CNT_W'(LONG_BITS - 1);
    localparam logic [CNT_W-1:0] L_FIRST = CNT_W'(HDR_W);

    logic                 lng;
    logic [CNT_W-1:0]     cnt;
    logic [LONG_DATA-1:0] sh;
    logic [CRC_W-1:0]     crc;
    logic [CNT_W-1:0]     ndata;
    logic [CNT_W-1:0]     first;
    logic [CNT_W-1:0]     lastc;
    logic [CSEL_W-1:0]    sel;
    logic                 accept;

    assign ndata  = lng ? L_DATA : S_DATA;
    assign first  = lng ? L_FIRST : '0;
    assign lastc  = lng ? L_LAST : S_LAST;
    assign accept = start && !busy;
    assign sel    = CSEL_W'(ndata + CNT_W'(CRC_W - 1) - cnt);

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy && (cnt >= first) && (cnt < ndata)),
        .init  (cnt == first),
        .din   (sh[LONG_DATA-1]),
        .crc   (crc)
    );

    // Load the frame on an accepted start, then shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            lng  <= 1'b0;
            cnt  <= '0;
            sh   <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            lng  <= long_sel;
            cnt  <= '0;
            if (long_sel)
                sh <= {2'b00, {IDX_W{1'b1}}, data};
            else
                sh <= {2'b00, idx, data[ARG_W-1:0], {(LONG_DATA-SHORT_DATA){1'b0}}};
        end else if (busy) begin
            sh <= {sh[LONG_DATA-2:0], 1'b0};
            if (cnt == lastc) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Pick the line value: payload, then CRC, then end bit; high when idle.
    always_comb begin
        if (!busy)
            line = 1'b1;
        else if (cnt < ndata)
            line = sh[LONG_DATA-1];
        else if (cnt < ndata + CNT_W'(CRC_W))
            line = crc[sel];
        else
            line = 1'b1;
    end
endmodule

// File: rtl/sdcmd_link.sv
// Command-line endpoint: token receiver plus response serializer.
// Assumes one line bit per clock in each direction. The card logic does not
// request a response while rsp_busy is high, and any such request is dropped.
module sdcmd_link #(
    parameter int IDX_W  = 6,
    parameter int ARG_W  = 32,
    parameter int BODY_W = 120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_in,
    output logic              cmd_valid,
    output logic              cmd_err,
    output logic [IDX_W-1:0]  cmd_idx,
    output logic [ARG_W-1:0]  cmd_arg,
    input  logic              rsp_start,
    input  logic              rsp_long,
    input  logic [IDX_W-1:0]  rsp_idx,
    input  logic [BODY_W-1:0] rsp_data,
    output logic              rsp_busy,
    output logic              cmd_out,
    output logic              cmd_oe
);
    logic tx_busy;

    sdcmd_rx #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_in    (cmd_in),
        .cmd_valid (cmd_valid),
        .cmd_err   (cmd_err),
        .cmd_idx   (cmd_idx),
        .cmd_arg   (cmd_arg)
    );

    sdcmd_tx #(.IDX_W(IDX_W), .ARG_W(ARG_W), .BODY_W(BODY_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rsp_start),
        .long_sel (rsp_long),
        .idx      (rsp_idx),
        .data     (rsp_data),
        .busy     (tx_busy),
        .line     (cmd_out)
    );

    assign rsp_busy = tx_busy;
    assign cmd_oe   = tx_busy;
endmodule

// File: rtl/sdcmd_link_chk.sv
// Port-level checker for sdcmd_link, attached by bind.
module sdcmd_link_chk #(
    parameter int IDX_W = 6,
    parameter int ARG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             cmd_err,
    input logic [IDX_W-1:0] cmd_idx,
    input logic [ARG_W-1:0] cmd_arg,
    input logic             rsp_start,
    input logic             rsp_busy,
    input logic             cmd_out,
    input logic             cmd_oe
);
    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_idx) && $stable(cmd_arg)));
    // R5
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_err));
    // R11
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_oe |-> cmd_out);
    // R9
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_out);
    // R11
    end_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_oe) |-> $past(cmd_out));
    // R12
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_start && !rsp_busy) |=> rsp_busy);
endmodule

bind sdcmd_link sdcmd_link_chk #(.IDX_W(IDX_W), .ARG_W(ARG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_err   (cmd_err),
    .cmd_idx   (cmd_idx),
    .cmd_arg   (cmd_arg),
    .rsp_start (rsp_start),
    .rsp_busy  (rsp_busy),
    .cmd_out   (cmd_out),
    .cmd_oe    (cmd_oe)
);

// File: tb/sdcmd_link_bench.sv
`timescale 1ns/1ps
module sdcmd_link_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_in = 1'b1;
    logic         cmd_valid, cmd_err;
    logic [5:0]   cmd_idx;
    logic [31:0]  cmd_arg;
    logic         rsp_start = 1'b0;
    logic         rsp_long = 1'b0;
    logic [5:0]   rsp_idx = '0;
    logic [119:0] rsp_data = '0;
    logic         rsp_busy, cmd_out, cmd_oe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct { bit ok; logic [5:0] idx; logic [31:0] arg; int due; string rq; } rx_item_t;
    typedef struct { int len; logic [135:0] bits; string rq; } tx_item_t;
    rx_item_t rxq[$];
    tx_item_t txq[$];
    logic [5:0]   last_idx = '0;
    logic [31:0]  last_arg = '0;
    logic [135:0] fr = '0;
    int           fr_n = 0;
    bit           busy_mis = 0;

    sdcmd_link u_sdcmd_link (
        .clk(clk), .rst_n(rst_n), .cmd_in(cmd_in),
        .cmd_valid(cmd_valid), .cmd_err(cmd_err), .cmd_idx(cmd_idx), .cmd_arg(cmd_arg),
        .rsp_start(rsp_start), .rsp_long(rsp_long), .rsp_idx(rsp_idx), .rsp_data(rsp_data),
        .rsp_busy(rsp_busy), .cmd_out(cmd_out), .cmd_oe(cmd_oe)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string rq, input bit pass, input logic [135:0] got, input logic [135:0] exp);
        checks++;
        if (!pass) begin
            errors++;
            $display("FAIL %s: got %h expected %h", rq, got, exp);
        end
    endtask

    function automatic logic [6:0] crc_ref(input logic [135:0] v, input int n);
        logic [6:0] c = '0;
        for (int i = n - 1; i >= 0; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    // Driver: send one host token and queue the expected event.
    task automatic send_tok(input logic dir, input logic [5:0] idx, input logic [31:0] arg,
                            input logic [6:0] flip, input logic endb, input string rq);
        logic [39:0] head;
        logic [47:0] tok;
        rx_item_t    it;
        bit          ok;
        head = {1'b0, dir, idx, arg};
        tok  = {head, crc_ref({96'b0, head}, 40) ^ flip, endb};
        for (int i = 47; i >= 0; i--) begin
            @(negedge clk);
            cmd_in = tok[i];
        end
        ok = dir && endb && (flip == '0);
        if (ok) begin
            last_idx = idx;
            last_arg = arg;
        end
        it.ok = ok; it.idx = last_idx; it.arg = last_arg; it.due = cyc + 1; it.rq = rq;
        rxq.push_back(it);
    endtask

    task automatic idle_line(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd_in = 1'b1;
        end
    endtask

    // Driver: request one response and queue the expected frame.
    task automatic send_rsp(input bit lng, input logic [5:0] idx, input logic [119:0] data,
                            input int poke_at, input string rq);
        tx_item_t it;
        logic [39:0] head;
        if (lng) begin
            it.len  = 136;
            it.bits = {2'b00, 6'h3F, data, crc_ref({16'b0, data}, 120), 1'b1};
        end else begin
            head    = {2'b00, idx, data[31:0]};
            it.len  = 48;
            it.bits = {88'b0, head, crc_ref({96'b0, head}, 40), 1'b1};
        end
        it.rq = rq;
        txq.push_back(it);
        @(negedge clk);
        rsp_start = 1'b1; rsp_long = lng; rsp_idx = idx; rsp_data = data;
        @(negedge clk);
        rsp_start = 1'b0;
        if (poke_at > 0) begin
            repeat (poke_at) @(negedge clk);
            rsp_start = 1'b1; rsp_long = !lng; rsp_idx = ~idx; rsp_data = ~data;
            @(negedge clk);
            rsp_start = 1'b0;
        end
        while (rsp_busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compare every receiver event and every transmitted frame.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cmd_valid || cmd_err) begin
                if (rxq.size() == 0) begin
                    check("R1 unexpected event", 1'b0, {cmd_valid, cmd_err}, 136'b0);
                end else begin
                    rx_item_t e;
                    e = rxq.pop_front();
                    check(e.rq, (cmd_valid === e.ok) && (cmd_err === !e.ok) &&
                          (cmd_idx === e.idx) && (cmd_arg === e.arg) && (cyc == e.due),
                          {cyc[15:0], cmd_valid, cmd_err, cmd_idx, cmd_arg},
                          {e.due[15:0], e.ok, !e.ok, e.idx, e.arg});
                end
            end
            if (cmd_oe) begin
                fr = {fr[134:0], cmd_out};
                fr_n++;
                if (rsp_busy !== 1'b1) busy_mis = 1;
            end else begin
                if (rsp_busy !== 1'b0 || cmd_out !== 1'b1) busy_mis = 1;
                if (fr_n > 0) begin
                    if (txq.size() == 0) begin
                        check("R12 extra frame", 1'b0, fr, 136'b0);
                    end else begin
                        tx_item_t e;
                        logic [135:0] m;
                        e = txq.pop_front();
                        m = {136{1'b1}} >> (136 - e.len);
                        check(e.rq, (fr_n == e.len) && ((fr & m) === e.bits),
                              (fr & m) | (136'(fr_n) << 128), e.bits | (136'(e.len) << 128));
                    end
                    check("R11 busy/oe/idle line", !busy_mis, 136'(busy_mis), 136'b0);
                    busy_mis = 0;
                    fr_n = 0;
                    fr = '0;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state", (cmd_valid === 1'b0) && (cmd_err === 1'b0) && (cmd_idx === 6'd0) &&
              (cmd_arg === 32'd0) && (cmd_oe === 1'b0) && (cmd_out === 1'b1) && (rsp_busy === 1'b0),
              {cmd_valid, cmd_err, cmd_idx, cmd_arg, cmd_oe, cmd_out, rsp_busy},
              {2'b00, 6'd0, 32'd0, 1'b0, 1'b1, 1'b0});
        idle_line(20);
        check("R1 idle line", rxq.size() == 0, 136'(rxq.size()), 136'b0);

        send_tok(1'b1, 6'd17, 32'h1234_5678, 7'h00, 1'b1, "R2 R3 R4 good token");
        idle_line(5);
        send_tok(1'b1, 6'd0, 32'h0000_0000, 7'h00, 1'b1, "R4 zero token");
        idle_line(3);
        send_tok(1'b1, 6'd63, 32'hFFFF_FFFF, 7'h00, 1'b1, "R3 R4 all-ones token");
        idle_line(3);
        send_tok(1'b1, 6'd8, 32'h0000_01AA, 7'h01, 1'b1, "R5 crc mismatch");
        idle_line(3);
        send_tok(1'b1, 6'd41, 32'hA5A5_0F0F, 7'h40, 1'b1, "R5 crc top bit flipped");
        idle_line(3);
        send_tok(1'b1, 6'd55, 32'hDEAD_BEEF, 7'h00, 1'b0, "R6 bad end bit");
        idle_line(3);
        send_tok(1'b0, 6'd12, 32'h0BAD_F00D, 7'h00, 1'b1, "R7 wrong direction");
        idle_line(3);
        send_tok(1'b1, 6'd2, 32'h8000_0001, 7'h00, 1'b1, "R8 back-to-back first");
        send_tok(1'b1, 6'd3, 32'h7FFF_FFFE, 7'h00, 1'b1, "R8 back-to-back second");
        send_tok(1'b1, 6'd9, 32'h0000_0000, 7'h22, 1'b1, "R8 R5 back-to-back bad");
        idle_line(6);
        check("R4 all events seen", rxq.size() == 0, 136'(rxq.size()), 136'b0);

        send_rsp(1'b0, 6'd17, 120'h0000_0000_0000_0000_0000_0000_0900, 0, "R9 short response");
        send_rsp(1'b0, 6'd63, {88'b0, 32'hFFFF_FFFF}, 0, "R9 short response ones");
        send_rsp(1'b1, 6'd0, 120'h0123_4567_89AB_CDEF_FEDC_BA98_7654_32, 0, "R10 long response");
        send_rsp(1'b1, 6'd5, '0, 0, "R10 long response zero body");
        send_rsp(1'b1, 6'd1, 120'hAAAA_5555_AAAA_5555_AAAA_5555_AAAA_55, 20, "R12 start while busy long");
        send_rsp(1'b0, 6'd33, {88'b0, 32'hC001_D00D}, 10, "R12 start while busy short");
        repeat (4) @(negedge clk);
        check("R12 no extra frame", (cmd_oe === 1'b0) && (txq.size() == 0),
              {cmd_oe, 8'(txq.size())}, 136'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule